// File: doc/BRIEF.md
# Boot ROM overlay memory mapper

This block watches a Z80-style processor bus and decides, for every memory or I/O cycle, which resource answers. On the memory side it chooses between a 4 KB boot ROM and a 64 KB RAM. On the I/O side it decodes the low address byte into chip selects for a DMA controller, a parallel I/O controller and a GPIB controller.

A one-bit overlay flag controls the memory map. Reset sets the flag, and while it is set every memory read returns the boot ROM, so the 4 KB image repeats across the whole 64 KB space. A single I/O read of the switch-off port clears the flag. From then on the low 60 KB read from RAM and the top 4 KB still read from ROM. Memory writes always go to RAM, so boot code can copy itself into RAM before it switches the overlay off.

All outputs are combinational from the bus strobes, the address and the registered flag. The only data path is a fixed idle byte returned by the switch-off port. This block has no streaming interface, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control level.

Top module: `boot_overlay_mapper`

## Requirements
- R1: After reset the overlay is on. A memory read (mreq_n=0, rd_n=0) at any address asserts rom_cs and leaves ram_cs low.
- R2: rom_offset always equals addr[11:0]. With the overlay on, reads at addresses 4 KB apart reach the same ROM byte.
- R3: A memory write (mreq_n=0, wr_n=0, rd_n=1) asserts ram_cs and never rom_cs, whatever the overlay state and address.
- R4: An I/O read (iorq_n=0, rd_n=0, m1_n=1) with addr[7:0]=0x1E clears the overlay. The flag changes at the first rising clock edge at which that read is no longer on the bus. The read itself sees the old map.
- R5: An I/O write to port 0x1E leaves the overlay unchanged.
- R6: With the overlay off, memory reads at 0x0000–0xEFFF assert ram_cs only, and reads at 0xF000–0xFFFF assert rom_cs only.
- R7: I/O cycles decode only addr[7:0]. Ports 0x00–0x03 assert dma_cs, ports 0x04–0x07 assert pio_cs, and ports 0x10–0x17 assert gpib_cs. addr[15:8] has no effect.
- R8: I/O ports outside those ranges assert no select. An I/O read of port 0x1E asserts io_rdata_oe and drives io_rdata=0xFF. At all other times io_rdata is 0x00 and io_rdata_oe is 0.
- R9: No peripheral select is asserted while iorq_n and m1_n are both low (interrupt acknowledge). No memory enable is asserted while mreq_n is high.
- R10: A reset after the overlay has been cleared turns the overlay back on.
- R11: rom_cs and ram_cs are never asserted together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples the bus strobes for the overlay flag |
| rst_n | input | 1 | Asynchronous active-low reset; sets the overlay |
| addr | input | 16 | Processor address bus |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode-fetch / interrupt-acknowledge marker, active low |
| rom_cs | output | 1 | Boot ROM enable |
| ram_cs | output | 1 | RAM enable |
| rom_offset | output | 12 | Byte offset into the boot ROM |
| dma_cs | output | 1 | DMA controller select |
| pio_cs | output | 1 | Parallel I/O controller select |
| gpib_cs | output | 1 | GPIB controller select |
| io_rdata | output | 8 | Idle byte returned by the switch-off port |
| io_rdata_oe | output | 1 | Drive enable for io_rdata |

## Verification
The bench uses the default parameters: a 16-bit address, a 4 KB ROM, an 8-bit port field, switch-off port 0x1E and idle byte 0xFF. With these values a uniformly random address lands in the top ROM window about one time in sixteen. A random port byte hits the 0x1E switch-off port often enough that the overlay is cleared and then restored by random resets many times in one run. The random upper address bytes on I/O cycles confirm that only the low byte is decoded. Short runs of vectors also reach the cycle right after a switch-off read, when the old map still applies.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;
  localparam int NUM_PERIPH = 3;

  typedef enum int {
    PER_DMA  = 0,
    PER_PIO  = 1,
    PER_GPIB = 2
  } periph_e;

  typedef struct packed {
    logic rom;
    logic ram;
  } mem_sel_t;
endpackage

// File: rtl/overlay_flag.sv
module overlay_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_hit,
  output logic overlay,
  output logic hit_q
);
  // The flag drops only once the qualifying read has left the bus.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overlay <= 1'b1;
      hit_q   <= 1'b0;
    end else begin
      hit_q <= clr_hit;
      if (hit_q && !clr_hit) overlay <= 1'b0;
    end
  end
endmodule

// File: rtl/mem_window_decode.sv
module mem_window_decode #(
  parameter int ADDR_W = 16,
  parameter int ROM_AW = 12
) (
  input  logic                  mem_rd,
  input  logic                  mem_wr,
  input  logic                  overlay,
  input  logic [ADDR_W-1:0]     addr,
  output bootmap_pkg::mem_sel_t sel,
  output logic [ROM_AW-1:0]     rom_offset
);
  localparam int PAGE_W = ADDR_W - ROM_AW;

  logic top_window;
  assign top_window = &addr[ADDR_W-1:ROM_AW];
  assign rom_offset = addr[ROM_AW-1:0];

  always_comb begin
    sel.rom = mem_rd && (overlay || top_window);
    sel.ram = mem_wr || (mem_rd && !overlay && !top_window);
  end

  // The top page number is an all-ones field of PAGE_W bits.
  if (PAGE_W < 1) begin : g_bad_geom
    initial $error("ROM must be smaller than the address space");
  end
endmodule

// File: rtl/io_port_decode.sv
module io_port_decode #(
  parameter int IO_AW = 8,
  parameter int NP    = bootmap_pkg::NUM_PERIPH,
  parameter logic [NP-1:0][IO_AW-1:0] PORT_BASE = {8'h10, 8'h04, 8'h00},
  parameter logic [NP-1:0][3:0]       PORT_LG   = {4'd3, 4'd2, 4'd2}
) (
  input  logic             io_cyc,
  input  logic [IO_AW-1:0] port,
  output logic [NP-1:0]    sel
);
  for (genvar g = 0; g < NP; g++) begin : g_port
    localparam int LG = int'(PORT_LG[g]);
    assign sel[g] = io_cyc && (port[IO_AW-1:LG] == PORT_BASE[g][IO_AW-1:LG]);
  end
endmodule

// File: rtl/boot_overlay_mapper.sv
module boot_overlay_mapper #(
  parameter int              ADDR_W   = 16,
  parameter int              ROM_AW   = 12,
  parameter int              IO_AW    = 8,
  parameter logic [IO_AW-1:0] OFF_PORT = 8'h1E,
  parameter logic [7:0]      IDLE_DAT = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mreq_n,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              m1_n,
  output logic              rom_cs,
  output logic              ram_cs,
  output logic [ROM_AW-1:0] rom_offset,
  output logic              dma_cs,
  output logic              pio_cs,
  output logic              gpib_cs,
  output logic [7:0]        io_rdata,
  output logic              io_rdata_oe
);
  import bootmap_pkg::*;

  logic mem_rd, mem_wr, io_cyc, clr_hit, overlay, hit_q;
  logic [IO_AW-1:0] port;
  logic [NUM_PERIPH-1:0] per_sel;
  mem_sel_t msel;

  assign port    = addr[IO_AW-1:0];
  assign mem_rd  = !mreq_n && !rd_n;
  assign mem_wr  = !mreq_n && !wr_n && rd_n;
  assign io_cyc  = !iorq_n && m1_n;
  assign clr_hit = io_cyc && !rd_n && (port == OFF_PORT);

  overlay_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_hit (clr_hit),
    .overlay (overlay),
    .hit_q   (hit_q)
  );

  mem_window_decode #(.ADDR_W(ADDR_W), .ROM_AW(ROM_AW)) u_mem (
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .overlay    (overlay),
    .addr       (addr),
    .sel        (msel),
    .rom_offset (rom_offset)
  );

  io_port_decode #(.IO_AW(IO_AW)) u_io (
    .io_cyc (io_cyc),
    .port   (port),
    .sel    (per_sel)
  );

  assign rom_cs      = msel.rom;
  assign ram_cs      = msel.ram;
  assign dma_cs      = per_sel[PER_DMA];
  assign pio_cs      = per_sel[PER_PIO];
  assign gpib_cs     = per_sel[PER_GPIB];
  assign io_rdata_oe = clr_hit;
  assign io_rdata    = clr_hit ? IDLE_DAT : 8'h00;
endmodule

// File: rtl/boot_overlay_mapper_chk.sv
module boot_overlay_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic        mreq_n,
  input logic        iorq_n,
  input logic        rd_n,
  input logic        wr_n,
  input logic        m1_n,
  input logic        rom_cs,
  input logic        ram_cs,
  input logic        dma_cs,
  input logic        pio_cs,
  input logic        gpib_cs,
  input logic        overlay,
  input logic        hit_q
);
  // R3
  mem_write_no_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && !wr_n && rd_n) |-> (ram_cs && !rom_cs));
  // R11
  mem_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_cs && ram_cs));
  // R9
  inta_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!iorq_n && !m1_n) |-> !(dma_cs || pio_cs || gpib_cs));
  // R9
  no_mreq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_n |-> !(rom_cs || ram_cs));
  // R6
  low_ram_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!overlay && !mreq_n && !rd_n && addr[15:12] != 4'hF) |-> (ram_cs && !rom_cs));
  // R5
  flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overlay && !hit_q) |=> overlay);
  // R7
  gpib_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gpib_cs |-> (addr[7:3] == 5'b00010));
endmodule

bind boot_overlay_mapper boot_overlay_mapper_chk chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n), .iorq_n(iorq_n),
  .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n), .rom_cs(rom_cs), .ram_cs(ram_cs),
  .dma_cs(dma_cs), .pio_cs(pio_cs), .gpib_cs(gpib_cs),
  .overlay(overlay), .hit_q(hit_q)
);

// File: tb/boot_overlay_mapper_tb.sv
module boot_overlay_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
  logic        rom_cs, ram_cs, dma_cs, pio_cs, gpib_cs, io_rdata_oe;
  logic [11:0] rom_offset;
  logic [7:0]  io_rdata;

  int n_chk = 0, n_bad = 0;
  logic m_ov = 1'b1, m_hit = 1'b0;
  bit   done = 0;

  always #10 clk = ~clk;

  boot_overlay_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n), .rom_cs(rom_cs), .ram_cs(ram_cs),
    .rom_offset(rom_offset), .dma_cs(dma_cs), .pio_cs(pio_cs), .gpib_cs(gpib_cs),
    .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe)
  );

  // Reference model: {rom, ram, offset, dma, pio, gpib, oe, data}
  function automatic logic [25:0] model(logic ov);
    logic mr, mw, io, rom, ram, dma, pio, gp, oe;
    mr  = !mreq_n && !rd_n;
    mw  = !mreq_n && !wr_n && rd_n;
    io  = !iorq_n && m1_n;
    rom = mr && (ov || addr[15:12] == 4'hF);
    ram = mw || (mr && !ov && addr[15:12] != 4'hF);
    dma = io && addr[7:0] <= 8'h03;
    pio = io && addr[7:0] >= 8'h04 && addr[7:0] <= 8'h07;
    gp  = io && addr[7:0] >= 8'h10 && addr[7:0] <= 8'h17;
    oe  = io && !rd_n && addr[7:0] == 8'h1E;
    return {rom, ram, addr[11:0], dma, pio, gp, oe, (oe ? 8'hFF : 8'h00)};
  endfunction

  function automatic logic model_hit();
    return !iorq_n && m1_n && !rd_n && addr[7:0] == 8'h1E;
  endfunction

  task automatic check(string req);
    logic [25:0] act, exp;
    act = {rom_cs, ram_cs, rom_offset, dma_cs, pio_cs, gpib_cs, io_rdata_oe, io_rdata};
    exp = model(m_ov);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h act=%h exp=%h", req, addr, act, exp);
    end
  endtask

  // Drive one bus vector for one clock, check mid-cycle, update model at edge.
  task automatic vec(logic mq, logic iq, logic r, logic w, logic m1, logic [15:0] a, string req);
    @(negedge clk);
    mreq_n = mq; iorq_n = iq; rd_n = r; wr_n = w; m1_n = m1; addr = a;
    #2;
    check(req);
    @(posedge clk);
    if (rst_n) begin
      if (m_hit && !model_hit()) m_ov = 1'b0;
      m_hit = model_hit();
    end
  endtask

  task automatic idle(string req);
    vec(1, 1, 1, 1, 1, 16'h0000, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; mreq_n = 1; iorq_n = 1; rd_n = 1; wr_n = 1; m1_n = 1;
    m_ov = 1'b1; m_hit = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    idle("R1 reset idle");
    vec(0, 1, 0, 1, 1, 16'h0123, "R1 overlay read low");
    vec(0, 1, 0, 1, 1, 16'h3ABC, "R2 mirror offset");
    vec(0, 1, 0, 1, 0, 16'h7ABC, "R2 mirror fetch");
    vec(0, 1, 1, 0, 1, 16'h2000, "R3 write under overlay");
    vec(0, 1, 1, 0, 1, 16'hF800, "R3 write top window");
    vec(1, 0, 1, 0, 1, 16'h001E, "R5 io write off port");
    idle("R5 after io write");
    vec(0, 1, 0, 1, 1, 16'h0100, "R5 overlay kept");
    vec(1, 0, 1, 1, 0, 16'h0002, "R9 int ack dma port");
    vec(1, 0, 1, 1, 0, 16'h001E, "R9 int ack off port");
    vec(1, 0, 0, 1, 1, 16'h5603, "R7 dma upper byte");
    vec(1, 0, 1, 0, 1, 16'hFF04, "R7 pio");
    vec(1, 0, 0, 1, 1, 16'h1217, "R7 gpib");
    vec(1, 0, 0, 1, 1, 16'h0018, "R8 unmapped");
    vec(1, 0, 0, 1, 1, 16'hAB1E, "R8 off port idle data");
    vec(1, 0, 0, 1, 1, 16'hAB1E, "R4 read held");
    idle("R4 end of read");
    vec(0, 1, 0, 1, 1, 16'h0100, "R4 ram after clear");
    vec(0, 1, 0, 1, 1, 16'hEFFF, "R6 last ram byte");
    vec(0, 1, 0, 1, 1, 16'hF000, "R6 first rom byte");
    vec(0, 1, 1, 0, 1, 16'hF123, "R3 write after clear");
    vec(1, 1, 0, 1, 1, 16'h0100, "R9 no mreq");
    do_reset();
    vec(0, 1, 0, 1, 1, 16'h0100, "R10 overlay restored");

    for (int i = 0; i < 6000; i++) begin
      int k;
      logic [15:0] a;
      k = int'($urandom_range(0, 99));
      a = 16'($urandom);
      if ($urandom_range(0, 7) == 0) a[7:0] = 8'h1E;
      if (i % 700 == 699) do_reset();
      if (k < 30)      vec(0, 1, 0, 1, 1, a, "R6 rand mem read");
      else if (k < 45) vec(0, 1, 1, 0, 1, a, "R3 rand mem write");
      else if (k < 65) vec(1, 0, 0, 1, 1, a, "R7 rand io read");
      else if (k < 80) vec(1, 0, 1, 0, 1, a, "R8 rand io write");
      else if (k < 88) vec(1, 0, 1, 1, 0, a, "R9 rand int ack");
      else             vec(1, 1, 1, 1, 1, a, "R11 rand idle");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule